// File: doc/BRIEF.md
# Hex Data Record Checker

This block reads a text stream of hexadecimal data records. It takes one ASCII character per valid/ready handshake. A record starts with the letter `S` followed by a type digit. Type `1` is a data record with a 16-bit address. The type is followed by a byte count, a big-endian address, the payload bytes and a checksum byte. Each byte is written as two hex characters, high nibble first. For every payload byte the block emits the byte and the memory address it belongs to. At the end of each record it raises one completion pulse with exactly one status flag: good, checksum error, format error or unsupported type.

In check mode the block adds every byte after the type, the checksum included, modulo 256. The record is good only when that sum is 0xFF. In generate mode the incoming record carries only the count, the address and the payload. The count still counts the missing checksum byte. After the last payload byte the block returns the ones-complement of the modulo-256 sum of those bytes, which is the checksum a sender would append.

All outputs are registered. A result caused by an accepted character is visible in the cycle after the clock edge that accepted it.

Top module: `srec_checker`

## Requirements
- R1: While reset is high and after it is released, every output pulse and flag is low; `in_ready` is high from the first clock edge after reset is released onward.
- R2: A byte field is two hex characters, the first one giving bits 7:4. The digits 0-9, A-F and a-f are all accepted, and the two letter cases give the same value.
- R3: For a type `1` record, the first payload byte is emitted with the address whose first field byte forms bits 15:8. Each later payload byte is emitted with the previous address plus one, modulo 2^16. `out_valid` pulses once per payload byte.
- R4: In check mode, when count + address bytes + payload + checksum equals 0xFF modulo 256, the checksum character's acceptance is followed by `rec_done` together with `rec_ok`.
- R5: In check mode, when that sum is not 0xFF, `rec_done` comes with `rec_csum_err`. Payload bytes already emitted stay emitted.
- R6: A non-hex character (CR and LF included) inside a count, address, payload or checksum field aborts the record. `rec_done` comes with `rec_fmt_err`, no further payload is emitted, and the block waits for the next `S`.
- R7: A count value below 3 produces `rec_done` with `rec_fmt_err` on its second character, and no payload is emitted.
- R8: A type digit other than `1` makes the block consume characters up to the next CR (0x0D) or LF (0x0A). On that character it raises `rec_done` with `rec_unsup` and emits no payload.
- R9: Outside a record, every character except `S` (0x53) is ignored and produces no output.
- R10: `gen_mode` is sampled on the `S` character. In generate mode the record ends after count-1 bytes (address and payload). On the second character of the last such byte the block raises `gen_valid` with `gen_sum` equal to the ones-complement of the modulo-256 sum of the count, address and payload bytes, together with `rec_done` and `rec_ok`.
- R11: Every `rec_done` pulse carries exactly one of `rec_ok`, `rec_csum_err`, `rec_fmt_err` and `rec_unsup`; none of the four is high without `rec_done`. All of these are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Block can take a character |
| in_char | input | 8 | ASCII character |
| gen_mode | input | 1 | 1: generate checksum, 0: check checksum |
| out_valid | output | 1 | Payload byte pulse |
| out_addr | output | 16 | Address of the emitted byte |
| out_data | output | 8 | Emitted payload byte |
| rec_done | output | 1 | Record finished pulse |
| rec_ok | output | 1 | Record good |
| rec_csum_err | output | 1 | Checksum mismatch |
| rec_fmt_err | output | 1 | Bad character or too small count |
| rec_unsup | output | 1 | Type other than 1 consumed |
| gen_valid | output | 1 | Generated checksum available |
| gen_sum | output | 8 | Generated checksum byte |

## Verification
The assertions rely on each payload byte and each record costing at least two accepted characters. Two payload pulses, or two completion pulses, can therefore never fall on adjacent cycles. Address continuity is checked only between pulses of the same record. The bench honours this by driving whole characters one per handshake and ending every record before starting the next. It also drives `gen_mode` stable from before the `S` until the record ends. It sweeps payload lengths from 0 to 15 over several base addresses, including one that wraps past 0xFFFF. Both letter cases are used, and both good and corrupted checksums are sent.

// File: rtl/srec_pkg.sv
package srec_pkg;

  typedef logic [7:0] char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TYPE,
    ST_COUNT,
    ST_ADDR_H,
    ST_ADDR_L,
    ST_BODY,
    ST_SKIP
  } srec_state_e;

  localparam char_t CH_START = 8'h53;  // 'S'
  localparam char_t CH_DATA  = 8'h31;  // '1'
  localparam char_t CH_CR    = 8'h0D;
  localparam char_t CH_LF    = 8'h0A;
  localparam logic [7:0] MIN_COUNT = 8'd3;
  localparam logic [7:0] SUM_GOOD  = 8'hFF;

  function automatic logic is_hex_char(char_t c);
    return (c >= 8'h30 && c <= 8'h39) ||
           (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_value(char_t c);
    logic [7:0] v;
    if (c >= 8'h30 && c <= 8'h39)      v = c - 8'h30;
    else if (c >= 8'h41 && c <= 8'h46) v = c - 8'h37;
    else if (c >= 8'h61 && c <= 8'h66) v = c - 8'h57;
    else                               v = 8'h00;
    return v[3:0];
  endfunction

  function automatic logic is_line_end(char_t c);
    return (c == CH_CR) || (c == CH_LF);
  endfunction

endpackage

// File: rtl/srec_hex_pair.sv
module srec_hex_pair
  import srec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  char_t             ch,
  output logic              is_hex,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int NIB_W = BYTE_W / 2;

  logic             second_q;
  logic [NIB_W-1:0] high_q;
  logic [NIB_W-1:0] nib;

  always_comb begin
    is_hex    = is_hex_char(ch);
    nib       = NIB_W'(hex_value(ch));
    byte_done = take && is_hex && second_q;
    byte_val  = {high_q, nib};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      second_q <= 1'b0;
      high_q   <= '0;
    end else if (take && is_hex) begin
      second_q <= ~second_q;
      if (!second_q) high_q <= nib;
    end
  end

endmodule

// File: rtl/srec_csum.sv
module srec_csum #(
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic [SUM_W-1:0] val,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst || clr) sum_q <= '0;
    else if (add)   sum_q <= sum_q + val;
  end

  assign sum = sum_q;

endmodule

// File: rtl/srec_parser.sv
module srec_parser
  import srec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  char_t             ch,
  input  logic              gen_mode_i,
  input  logic              is_hex,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [BYTE_W-1:0] sum_i,
  output logic              take,
  output logic              rec_start,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BYTE_W-1:0] out_data,
  output logic              done,
  output logic              ok,
  output logic              csum_err,
  output logic              fmt_err,
  output logic              unsup,
  output logic              gen_valid,
  output logic [BYTE_W-1:0] gen_sum
);
  srec_state_e       state_q;
  logic [BYTE_W-1:0] left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              gen_q;
  logic              in_field;
  logic [BYTE_W-1:0] sum_next;

  always_comb begin
    in_field  = (state_q == ST_COUNT) || (state_q == ST_ADDR_H) ||
                (state_q == ST_ADDR_L) || (state_q == ST_BODY);
    take      = acc && in_field;
    rec_start = acc && (state_q == ST_IDLE) && (ch == CH_START);
    sum_next  = sum_i + byte_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      addr_q    <= '0;
      gen_q     <= 1'b0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
      csum_err  <= 1'b0;
      fmt_err   <= 1'b0;
      unsup     <= 1'b0;
      gen_valid <= 1'b0;
      gen_sum   <= '0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
      csum_err  <= 1'b0;
      fmt_err   <= 1'b0;
      unsup     <= 1'b0;
      gen_valid <= 1'b0;
      if (acc) begin
        if (in_field && !is_hex) begin
          done    <= 1'b1;
          fmt_err <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          case (state_q)
            ST_IDLE: begin
              if (ch == CH_START) begin
                state_q <= ST_TYPE;
                gen_q   <= gen_mode_i;
              end
            end
            ST_TYPE: begin
              if (ch == CH_DATA) begin
                state_q <= ST_COUNT;
              end else if (is_line_end(ch)) begin
                done    <= 1'b1;
                unsup   <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_SKIP: begin
              if (is_line_end(ch)) begin
                done    <= 1'b1;
                unsup   <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
            ST_COUNT: begin
              if (byte_done) begin
                if (byte_val < MIN_COUNT) begin
                  done    <= 1'b1;
                  fmt_err <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  left_q  <= byte_val;
                  state_q <= ST_ADDR_H;
                end
              end
            end
            ST_ADDR_H: begin
              if (byte_done) begin
                addr_q[ADDR_W-1 -: BYTE_W] <= byte_val;
                left_q  <= left_q - 1'b1;
                state_q <= ST_ADDR_L;
              end
            end
            ST_ADDR_L: begin
              if (byte_done) begin
                addr_q[BYTE_W-1:0] <= byte_val;
                left_q <= left_q - 1'b1;
                if (gen_q && left_q == BYTE_W'(2)) begin
                  gen_valid <= 1'b1;
                  gen_sum   <= ~sum_next;
                  done      <= 1'b1;
                  ok        <= 1'b1;
                  state_q   <= ST_IDLE;
                end else begin
                  state_q <= ST_BODY;
                end
              end
            end
            ST_BODY: begin
              if (byte_done) begin
                if (left_q == BYTE_W'(1)) begin
                  done     <= 1'b1;
                  ok       <= (sum_next == SUM_GOOD);
                  csum_err <= (sum_next != SUM_GOOD);
                  state_q  <= ST_IDLE;
                end else begin
                  out_valid <= 1'b1;
                  out_data  <= byte_val;
                  out_addr  <= addr_q;
                  addr_q    <= addr_q + ADDR_W'(1);
                  left_q    <= left_q - 1'b1;
                  if (gen_q && left_q == BYTE_W'(2)) begin
                    gen_valid <= 1'b1;
                    gen_sum   <= ~sum_next;
                    done      <= 1'b1;
                    ok        <= 1'b1;
                    state_q   <= ST_IDLE;
                  end
                end
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/srec_checker.sv
module srec_checker
  import srec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_char,
  input  logic              gen_mode,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BYTE_W-1:0] out_data,
  output logic              rec_done,
  output logic              rec_ok,
  output logic              rec_csum_err,
  output logic              rec_fmt_err,
  output logic              rec_unsup,
  output logic              gen_valid,
  output logic [BYTE_W-1:0] gen_sum
);
  logic              ready_q;
  logic              acc;
  logic              take;
  logic              rec_start;
  logic              is_hex;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [BYTE_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign acc      = in_valid && ready_q;

  srec_hex_pair #(.BYTE_W(BYTE_W)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .clr       (rec_start),
    .take      (take),
    .ch        (in_char),
    .is_hex    (is_hex),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  srec_csum #(.SUM_W(BYTE_W)) u_csum (
    .clk (clk),
    .rst (rst),
    .clr (rec_start),
    .add (byte_done),
    .val (byte_val),
    .sum (sum)
  );

  srec_parser #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_parser (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .ch         (in_char),
    .gen_mode_i (gen_mode),
    .is_hex     (is_hex),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .sum_i      (sum),
    .take       (take),
    .rec_start  (rec_start),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_data   (out_data),
    .done       (rec_done),
    .ok         (rec_ok),
    .csum_err   (rec_csum_err),
    .fmt_err    (rec_fmt_err),
    .unsup      (rec_unsup),
    .gen_valid  (gen_valid),
    .gen_sum    (gen_sum)
  );

endmodule

// File: rtl/srec_checker_sva.sv
module srec_checker_sva #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              rec_done,
  input logic              rec_ok,
  input logic              rec_csum_err,
  input logic              rec_fmt_err,
  input logic              rec_unsup,
  input logic              gen_valid
);
  logic              seen_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else begin
      if (out_valid) begin
        seen_q <= 1'b1;
        prev_q <= out_addr;
      end
      if (rec_done) seen_q <= 1'b0;
    end
  end

  // R11
  status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> $countones({rec_ok, rec_csum_err, rec_fmt_err, rec_unsup}) == 1);

  // R11
  status_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    !rec_done |-> ({rec_ok, rec_csum_err, rec_fmt_err, rec_unsup} == 4'b0000));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !rec_done);

  // R10
  gen_with_ok_chk: assert property (@(posedge clk) disable iff (rst)
    gen_valid |-> (rec_done && rec_ok));

  // R3
  data_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen_q) |-> (out_addr == prev_q + ADDR_W'(1)));

endmodule

bind srec_checker srec_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .out_valid    (out_valid),
  .out_addr     (out_addr),
  .rec_done     (rec_done),
  .rec_ok       (rec_ok),
  .rec_csum_err (rec_csum_err),
  .rec_fmt_err  (rec_fmt_err),
  .rec_unsup    (rec_unsup),
  .gen_valid    (gen_valid)
);

// File: tb/srec_checker_tb.sv
`timescale 1ns/1ps
module srec_checker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_char = 8'h00;
  logic        gen_mode = 1'b0;
  logic        out_valid;
  logic [15:0] out_addr;
  logic [7:0]  out_data;
  logic        rec_done, rec_ok, rec_csum_err, rec_fmt_err, rec_unsup;
  logic        gen_valid;
  logic [7:0]  gen_sum;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  g_data [0:63];
  logic [15:0] g_addr [0:63];
  logic [7:0]  dbuf   [0:63];
  int          n_got = 0;
  int          n_done = 0;
  logic [3:0]  g_flags = 4'b0;  // {ok, csum_err, fmt_err, unsup}
  bit          g_gv = 1'b0;
  logic [7:0]  g_gsum = 8'h00;

  always #2.5 clk = ~clk;

  srec_checker u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .gen_mode(gen_mode), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data), .rec_done(rec_done),
    .rec_ok(rec_ok), .rec_csum_err(rec_csum_err), .rec_fmt_err(rec_fmt_err),
    .rec_unsup(rec_unsup), .gen_valid(gen_valid), .gen_sum(gen_sum)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (n_got < 64) begin
          g_data[n_got] = out_data;
          g_addr[n_got] = out_addr;
        end
        n_got = n_got + 1;
      end
      if (rec_done) begin
        n_done  = n_done + 1;
        g_flags = g_flags | {rec_ok, rec_csum_err, rec_fmt_err, rec_unsup};
      end
      if (gen_valid) begin
        g_gv   = 1'b1;
        g_gsum = gen_sum;
      end
    end
  end

  task automatic chk(input bit good, input string req, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!good) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lo);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lo ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
  endfunction

  task automatic send(input logic [7:0] c);
    in_valid = 1'b1;
    in_char  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lo);
    send(hexc(b[7:4], lo));
    send(hexc(b[3:0], lo));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_mon();
    n_got = 0; n_done = 0; g_flags = 4'b0; g_gv = 1'b0; g_gsum = 8'h00;
  endtask

  task automatic run_rec(input int n, input logic [15:0] addr, input int seed,
                         input bit lo, input bit gen, input bit corrupt);
    logic [7:0] cnt, sum, cs;
    int bad;
    logic [3:0] exp_flags;
    cnt = 8'(n + 3);
    sum = cnt + addr[15:8] + addr[7:0];
    for (int i = 0; i < n; i++) begin
      dbuf[i] = 8'((seed * 37 + i * 11 + 5));
      sum = sum + dbuf[i];
    end
    cs = ~sum;
    if (corrupt) cs = cs ^ 8'h10;
    gen_mode = gen;
    clear_mon();
    send(8'h53); send(8'h31);
    send_byte(cnt, lo);
    send_byte(addr[15:8], lo);
    send_byte(addr[7:0], lo);
    for (int i = 0; i < n; i++) send_byte(dbuf[i], lo);
    if (!gen) send_byte(cs, lo);
    send(8'h0D); send(8'h0A);
    idle(2);
    chk(n_got == n, "R3 payload count", n_got, n);
    bad = 0;
    for (int i = 0; i < n && i < 64; i++)
      if (g_data[i] !== dbuf[i] || g_addr[i] !== 16'(addr + 16'(i))) bad++;
    chk(bad == 0, "R2/R3 payload value or address", bad, 0);
    chk(n_done == 1, "R11 one completion", n_done, 1);
    exp_flags = gen ? 4'b1000 : (corrupt ? 4'b0100 : 4'b1000);
    if (gen) chk(g_flags == exp_flags, "R10 status", g_flags, exp_flags);
    else if (corrupt) chk(g_flags == exp_flags, "R5 status", g_flags, exp_flags);
    else chk(g_flags == exp_flags, "R4 status", g_flags, exp_flags);
    if (gen) chk(g_gv && g_gsum == ~sum, "R10 generated checksum", g_gsum, ~sum);
    else chk(!g_gv, "R10 no generate in check mode", g_gv, 0);
    gen_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk = n_chk + 1;
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(1);
    chk({out_valid, rec_done, rec_ok, rec_csum_err, rec_fmt_err, rec_unsup, gen_valid} == 7'b0,
        "R1 outputs low in reset", 1, 0);
    idle(3);
    rst = 1'b0;
    idle(2);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk({out_valid, rec_done, gen_valid} == 3'b0, "R1 outputs idle", 1, 0);

    // R9: stray characters between records
    clear_mon();
    send(8'h0D); send(8'h0A); send(8'h78); send(8'h31); send(8'h41); send(8'h20); send(8'h39);
    idle(2);
    chk(n_got == 0 && n_done == 0, "R9 stray characters ignored", n_got + n_done, 0);

    // R2 R3 R4 R5: sweep of lengths, bases, letter case and corruption
    for (int n = 0; n < 16; n++) begin
      run_rec(n, 16'h0000, n, 1'b0, 1'b0, (n % 3) == 2);
      run_rec(n, 16'h1234 + 16'(n * 256), n + 7, 1'b1, 1'b0, 1'b0);
      run_rec(n, 16'hFFF8, n + 3, (n % 2) == 1, 1'b0, (n % 4) == 1);
    end

    // R10: generate mode over lengths, count of 3 included
    for (int n = 0; n < 9; n++) run_rec(n, 16'hA5F0 + 16'(n), n + 11, (n % 2) == 0, 1'b1, 1'b0);

    // R6: bad character inside the address
    clear_mon();
    send(8'h53); send(8'h31); send_byte(8'h09, 1'b0); send(8'h32); send(8'h47);
    send(8'h30); send(8'h30); send(8'h0D); send(8'h0A); idle(2);
    chk(n_done == 1 && g_flags == 4'b0010, "R6 bad char in address", g_flags, 4'b0010);
    chk(n_got == 0, "R6 no payload after abort", n_got, 0);

    // R6: bad character after one good payload byte
    clear_mon();
    send(8'h53); send(8'h31); send_byte(8'h06, 1'b0); send_byte(8'h20, 1'b0); send_byte(8'h00, 1'b0);
    send_byte(8'h5A, 1'b0); send(8'h5A); send_byte(8'h77, 1'b0); send(8'h0D); idle(2);
    chk(n_got == 1 && g_data[0] == 8'h5A && g_addr[0] == 16'h2000, "R6 payload before abort", n_got, 1);
    chk(n_done == 1 && g_flags == 4'b0010, "R6 abort status", g_flags, 4'b0010);

    // R6: line end inside a record
    clear_mon();
    send(8'h53); send(8'h31); send(8'h30); send(8'h0A); idle(2);
    chk(n_done == 1 && g_flags == 4'b0010, "R6 line end in count", g_flags, 4'b0010);

    // R7: counts 2 and 0
    clear_mon();
    send(8'h53); send(8'h31); send_byte(8'h02, 1'b0); send_byte(8'h10, 1'b0); send(8'h0D); idle(2);
    chk(n_done == 1 && g_flags == 4'b0010 && n_got == 0, "R7 count 2", g_flags, 4'b0010);
    clear_mon();
    send(8'h53); send(8'h31); send_byte(8'h00, 1'b0); send(8'h0D); idle(2);
    chk(n_done == 1 && g_flags == 4'b0010 && n_got == 0, "R7 count 0", g_flags, 4'b0010);

    // R8: terminator-type record consumed to line end
    clear_mon();
    send(8'h53); send(8'h39); send_byte(8'h03, 1'b0); send_byte(8'h00, 1'b0);
    send_byte(8'h00, 1'b0); send_byte(8'hFC, 1'b0); idle(2);
    chk(n_done == 0, "R8 no completion before line end", n_done, 0);
    send(8'h0D); send(8'h0A); idle(2);
    chk(n_done == 1 && g_flags == 4'b0001 && n_got == 0, "R8 unsupported type", g_flags, 4'b0001);

    // R8: header-type record ended by LF only
    clear_mon();
    send(8'h53); send(8'h30); send_byte(8'h05, 1'b1); send(8'h0A); idle(2);
    chk(n_done == 1 && g_flags == 4'b0001, "R8 header type", g_flags, 4'b0001);

    // R4: good record still accepted after the error cases
    run_rec(4, 16'h0100, 99, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule